// File: doc/BRIEF.md
# Interrupt Domain Register Decoder

This block sits behind a simple request/response register port of an interrupt domain. It turns 32-bit register accesses into control actions. Per-source trigger modes, per-source delivery targets, the domain enable bit and the last generated-message word all live inside the block. The per-source pending, enable and rectified-input state lives in a neighbouring gateway. The block reads that state through three input vectors and changes it through one-cycle strobe vectors: set-pending, clear-pending, set-enable and clear-enable.

Each accepted request is answered exactly one cycle later with read data or an error flag. Any strobes caused by a write appear in that same response cycle. Every successful write also pulses a rescan strobe, so that the forwarding engine re-examines all sources. A write to the generate-message register emits a message-request strobe carrying the hart and identity fields.

Source numbers run from 1 to `NUM_SRC`; number 0 is reserved. Bit b of word w in any word array stands for source 32·w+b. There are `NWORD = ceil((NUM_SRC+1)/32)` words per array.

Top module: `ird_top`

## Requirements
- R1: A request whose offset has either of its two low bits set, or whose size is not 4, gets an error response with read data 0, produces no strobe and changes no stored state.
- R2: `rspValid` is high exactly in the cycle after each cycle with `reqValid` high and low otherwise. All strobes last one cycle and occur only in a response cycle without error.
- R3: The domain register is at offset 0x0000 and resets to 0. A read returns 0x8000_0004 with bit 8 equal to the stored enable. A write stores only wdata bit 8, which drives `domainEnable`.
- R4: Mode entry k (0 ≤ k < NUM_SRC) is at 0x0004+4k and belongs to source k+1. It resets to 0. A write with wdata bit 10 set stores 0; otherwise it stores wdata[2:0]. A read returns the stored value, and `srcMode[3k+2:3k]` shows it.
- R5: Target entry k is at 0x3004+4k and belongs to source k+1. It resets to 0. A write stores wdata with bit 11 cleared, a read returns the stored value, and `srcTarget[32k+31:32k]` shows it.
- R6: Word arrays sit at 0x1C00 (set-pending), 0x1D00 (clear-pending), 0x1E00 (set-enable) and 0x1F00 (clear-enable), each NWORD words long. Reads return `pendIn`, `lvlIn`, `enIn` and 0 respectively. Bits for source 0 or beyond NUM_SRC read 0.
- R7: A word-array write strobes, on the matching vector, every in-range source whose bit is 1. Sources whose bit is 0 are not strobed.
- R8: By-number registers are set-pending at 0x1CDC and 0x2000, clear-pending at 0x1DDC, set-enable at 0x1EDC and clear-enable at 0x1FDC. A write of n with 1 ≤ n ≤ NUM_SRC strobes source n; any other n strobes nothing. Reads return 0.
- R9: A write to 0x2004 byte-swaps wdata and uses the result as a set-pending source number.
- R10: A write to 0x3000 stores wdata with bits 17:12 cleared, which reads back. It pulses `genMsgStb` with `genMsgHart` = wdata[31:18] and `genMsgEiid` = wdata[10:0].
- R11: An aligned 4-byte access to any offset outside the regions above gets an error response and has no effect.
- R12: `rescanStb` pulses in the response cycle of every write without error, and never for reads or errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte offset of the access |
| reqSize | input | 3 | Access size in bytes |
| reqWdata | input | 32 | Write data |
| pendIn | input | NUM_SRC | Pending bits, bit s is source s |
| enIn | input | NUM_SRC | Enable bits, bit s is source s |
| lvlIn | input | NUM_SRC | Rectified input levels, bit s is source s |
| rspValid | output | 1 | Response cycle |
| rspError | output | 1 | Access rejected |
| rspRdata | output | 32 | Read data |
| domainEnable | output | 1 | Stored domain enable |
| srcMode | output | 3*NUM_SRC | Trigger mode per source |
| srcTarget | output | 32*NUM_SRC | Target word per source |
| setPendStb | output | NUM_SRC | Set-pending strobes |
| clrPendStb | output | NUM_SRC | Clear-pending strobes |
| setEnStb | output | NUM_SRC | Set-enable strobes |
| clrEnStb | output | NUM_SRC | Clear-enable strobes |
| genMsgStb | output | 1 | Message request strobe |
| genMsgHart | output | 14 | Hart field of message request |
| genMsgEiid | output | 11 | Identity field of message request |
| rescanStb | output | 1 | Re-examine all sources |

## Verification
The two functions that share a cycle are these: the strobes and stored-state update of one write, and the decode and read of the next request. The bench issues requests back to back, so a mode or target write is followed at once by a read of the same entry. A word write is likewise followed at once by a read of the same array. The reference model applies the write at the response edge and expects the read issued in that cycle to return the new value. It also expects the strobes of the earlier write and the response of the later read on consecutive clocks, each exactly once.

// File: rtl/ird_pkg.sv
package ird_pkg;
  localparam int IDX_W = 10;

  localparam logic [31:0] OFF_DCFG  = 32'h0000;
  localparam logic [31:0] OFF_SCFG  = 32'h0004;
  localparam logic [31:0] OFF_SETP  = 32'h1C00;
  localparam logic [31:0] OFF_SETPN = 32'h1CDC;
  localparam logic [31:0] OFF_CLRP  = 32'h1D00;
  localparam logic [31:0] OFF_CLRPN = 32'h1DDC;
  localparam logic [31:0] OFF_SETE  = 32'h1E00;
  localparam logic [31:0] OFF_SETEN = 32'h1EDC;
  localparam logic [31:0] OFF_CLRE  = 32'h1F00;
  localparam logic [31:0] OFF_CLREN = 32'h1FDC;
  localparam logic [31:0] OFF_NUMLE = 32'h2000;
  localparam logic [31:0] OFF_NUMBE = 32'h2004;
  localparam logic [31:0] OFF_GEN   = 32'h3000;
  localparam logic [31:0] OFF_TGT   = 32'h3004;

  localparam logic [31:0] DCFG_FIXED  = 32'h8000_0004;
  localparam int          DCFG_IE_BIT = 8;
  localparam int          CFG_DELEG_BIT = 10;
  localparam logic [31:0] TGT_KEEP    = 32'hFFFF_F7FF;
  localparam logic [31:0] GEN_KEEP    = 32'hFFFC_0FFF;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DCFG, SEL_SCFG, SEL_SETP_W, SEL_SETP_N, SEL_CLRP_W,
    SEL_CLRP_N, SEL_SETE_W, SEL_SETE_N, SEL_CLRE_W, SEL_CLRE_N,
    SEL_NUM_LE, SEL_NUM_BE, SEL_GEN, SEL_TGT
  } regSel_e;

  typedef struct packed {
    logic             fire;
    logic             write;
    logic             fault;
    regSel_e          sel;
    logic [IDX_W-1:0] idx;
  } decCmd_t;
endpackage

// File: rtl/ird_ctrl.sv
module ird_ctrl
  import ird_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int NUM_SRC = 40
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  output decCmd_t           cmd
);
  localparam int          NWORD      = (NUM_SRC + 32) / 32;
  localparam logic [31:0] ARR_BYTES  = 32'(NUM_SRC * 4);
  localparam logic [31:0] WORD_BYTES = 32'(NWORD * 4);

  logic [31:0]      off;
  logic             aligned;
  regSel_e          sel;
  logic [IDX_W-1:0] idx;

  assign off     = 32'(reqAddr);
  assign aligned = (off[1:0] == 2'b00) && (reqSize == 3'd4);

  function automatic logic inWin(logic [31:0] o, logic [31:0] base, logic [31:0] len);
    return (o >= base) && (o < base + len);
  endfunction

  function automatic logic [IDX_W-1:0] slot(logic [31:0] o, logic [31:0] base);
    return IDX_W'((o - base) >> 2);
  endfunction

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (!aligned) begin
      sel = SEL_NONE;
    end else if (off == OFF_DCFG) begin
      sel = SEL_DCFG;
    end else if (inWin(off, OFF_SCFG, ARR_BYTES)) begin
      sel = SEL_SCFG;   idx = slot(off, OFF_SCFG);
    end else if (inWin(off, OFF_SETP, WORD_BYTES)) begin
      sel = SEL_SETP_W; idx = slot(off, OFF_SETP);
    end else if (off == OFF_SETPN) begin
      sel = SEL_SETP_N;
    end else if (inWin(off, OFF_CLRP, WORD_BYTES)) begin
      sel = SEL_CLRP_W; idx = slot(off, OFF_CLRP);
    end else if (off == OFF_CLRPN) begin
      sel = SEL_CLRP_N;
    end else if (inWin(off, OFF_SETE, WORD_BYTES)) begin
      sel = SEL_SETE_W; idx = slot(off, OFF_SETE);
    end else if (off == OFF_SETEN) begin
      sel = SEL_SETE_N;
    end else if (inWin(off, OFF_CLRE, WORD_BYTES)) begin
      sel = SEL_CLRE_W; idx = slot(off, OFF_CLRE);
    end else if (off == OFF_CLREN) begin
      sel = SEL_CLRE_N;
    end else if (off == OFF_NUMLE) begin
      sel = SEL_NUM_LE;
    end else if (off == OFF_NUMBE) begin
      sel = SEL_NUM_BE;
    end else if (off == OFF_GEN) begin
      sel = SEL_GEN;
    end else if (inWin(off, OFF_TGT, ARR_BYTES)) begin
      sel = SEL_TGT;    idx = slot(off, OFF_TGT);
    end
  end

  assign cmd.fire  = reqValid;
  assign cmd.write = reqWrite;
  assign cmd.fault = (sel == SEL_NONE);
  assign cmd.sel   = sel;
  assign cmd.idx   = idx;
endmodule

// File: rtl/ird_dpath.sv
module ird_dpath
  import ird_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  decCmd_t                cmd,
  input  logic [31:0]            reqWdata,
  input  logic [NUM_SRC:1]       pendIn,
  input  logic [NUM_SRC:1]       enIn,
  input  logic [NUM_SRC:1]       lvlIn,
  output logic                   rspValid,
  output logic                   rspError,
  output logic [31:0]            rspRdata,
  output logic                   domainEnable,
  output logic [3*NUM_SRC-1:0]   srcMode,
  output logic [32*NUM_SRC-1:0]  srcTarget,
  output logic [NUM_SRC:1]       setPendStb,
  output logic [NUM_SRC:1]       clrPendStb,
  output logic [NUM_SRC:1]       setEnStb,
  output logic [NUM_SRC:1]       clrEnStb,
  output logic                   genMsgStb,
  output logic [13:0]            genMsgHart,
  output logic [10:0]            genMsgEiid,
  output logic                   rescanStb
);
  localparam int NWORD = (NUM_SRC + 32) / 32;
  localparam int PAD_W = NWORD * 32;

  logic              wrOk, rdOk;
  logic              ieQ;
  logic [31:0]       genQ;
  logic [3*NUM_SRC-1:0]  modeFlat;
  logic [32*NUM_SRC-1:0] tgtFlat;
  logic [NUM_SRC:1]  wordVec, numVec;
  logic [31:0]       srcNum, rdVal;
  logic [NUM_SRC:1]  nSetP, nClrP, nSetE, nClrE;

  assign wrOk = cmd.fire &&  cmd.write && !cmd.fault;
  assign rdOk = cmd.fire && !cmd.write && !cmd.fault;

  // per-source storage
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic [2:0]  modeR;
    logic [31:0] tgtR;
    logic        hitMode, hitTgt;
    assign hitMode = wrOk && (cmd.sel == SEL_SCFG) && (cmd.idx == IDX_W'(k));
    assign hitTgt  = wrOk && (cmd.sel == SEL_TGT)  && (cmd.idx == IDX_W'(k));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeR <= '0;
        tgtR  <= '0;
      end else begin
        if (hitMode) modeR <= reqWdata[CFG_DELEG_BIT] ? 3'd0 : reqWdata[2:0];
        if (hitTgt)  tgtR  <= reqWdata & TGT_KEEP;
      end
    end
    assign modeFlat[3*k +: 3] = modeR;
    assign tgtFlat[32*k +: 32] = tgtR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieQ  <= 1'b0;
      genQ <= '0;
    end else begin
      if (wrOk && cmd.sel == SEL_DCFG) ieQ  <= reqWdata[DCFG_IE_BIT];
      if (wrOk && cmd.sel == SEL_GEN)  genQ <= reqWdata & GEN_KEEP;
    end
  end

  function automatic logic [31:0] pickWord(logic [NUM_SRC:1] v, logic [IDX_W-1:0] w);
    logic [PAD_W-1:0] pad;
    pad = PAD_W'({v, 1'b0});
    return pad[32*int'(w) +: 32];
  endfunction

  // write vectors
  assign srcNum = (cmd.sel == SEL_NUM_BE)
                ? {reqWdata[7:0], reqWdata[15:8], reqWdata[23:16], reqWdata[31:24]}
                : reqWdata;

  always_comb begin
    for (int s = 1; s <= NUM_SRC; s++) begin
      wordVec[s] = (s / 32 == int'(cmd.idx)) && reqWdata[s % 32];
      numVec[s]  = (srcNum == 32'(s));
    end
  end

  always_comb begin
    nSetP = '0; nClrP = '0; nSetE = '0; nClrE = '0;
    if (wrOk) begin
      case (cmd.sel)
        SEL_SETP_W: nSetP = wordVec;
        SEL_SETP_N, SEL_NUM_LE, SEL_NUM_BE: nSetP = numVec;
        SEL_CLRP_W: nClrP = wordVec;
        SEL_CLRP_N: nClrP = numVec;
        SEL_SETE_W: nSetE = wordVec;
        SEL_SETE_N: nSetE = numVec;
        SEL_CLRE_W: nClrE = wordVec;
        SEL_CLRE_N: nClrE = numVec;
        default: ;
      endcase
    end
  end

  // read mux
  always_comb begin
    case (cmd.sel)
      SEL_DCFG:   rdVal = DCFG_FIXED | (32'(ieQ) << DCFG_IE_BIT);
      SEL_SCFG:   rdVal = 32'(modeFlat[3*int'(cmd.idx) +: 3]);
      SEL_SETP_W: rdVal = pickWord(pendIn, cmd.idx);
      SEL_CLRP_W: rdVal = pickWord(lvlIn, cmd.idx);
      SEL_SETE_W: rdVal = pickWord(enIn, cmd.idx);
      SEL_GEN:    rdVal = genQ;
      SEL_TGT:    rdVal = tgtFlat[32*int'(cmd.idx) +: 32];
      default:    rdVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspError   <= 1'b0;
      rspRdata   <= '0;
      setPendStb <= '0;
      clrPendStb <= '0;
      setEnStb   <= '0;
      clrEnStb   <= '0;
      genMsgStb  <= 1'b0;
      genMsgHart <= '0;
      genMsgEiid <= '0;
      rescanStb  <= 1'b0;
    end else begin
      rspValid   <= cmd.fire;
      rspError   <= cmd.fire && cmd.fault;
      rspRdata   <= rdOk ? rdVal : 32'd0;
      setPendStb <= nSetP;
      clrPendStb <= nClrP;
      setEnStb   <= nSetE;
      clrEnStb   <= nClrE;
      genMsgStb  <= wrOk && (cmd.sel == SEL_GEN);
      genMsgHart <= (wrOk && cmd.sel == SEL_GEN) ? reqWdata[31:18] : 14'd0;
      genMsgEiid <= (wrOk && cmd.sel == SEL_GEN) ? reqWdata[10:0]  : 11'd0;
      rescanStb  <= wrOk;
    end
  end

  assign domainEnable = ieQ;
  assign srcMode      = modeFlat;
  assign srcTarget    = tgtFlat;
endmodule

// File: rtl/ird_top.sv
module ird_top
  import ird_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int NUM_SRC = 40
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [2:0]            reqSize,
  input  logic [31:0]           reqWdata,
  input  logic [NUM_SRC:1]      pendIn,
  input  logic [NUM_SRC:1]      enIn,
  input  logic [NUM_SRC:1]      lvlIn,
  output logic                  rspValid,
  output logic                  rspError,
  output logic [31:0]           rspRdata,
  output logic                  domainEnable,
  output logic [3*NUM_SRC-1:0]  srcMode,
  output logic [32*NUM_SRC-1:0] srcTarget,
  output logic [NUM_SRC:1]      setPendStb,
  output logic [NUM_SRC:1]      clrPendStb,
  output logic [NUM_SRC:1]      setEnStb,
  output logic [NUM_SRC:1]      clrEnStb,
  output logic                  genMsgStb,
  output logic [13:0]           genMsgHart,
  output logic [10:0]           genMsgEiid,
  output logic                  rescanStb
);
  decCmd_t cmd;

  ird_ctrl #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqSize(reqSize), .cmd(cmd)
  );

  ird_dpath #(.NUM_SRC(NUM_SRC)) u_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .reqWdata(reqWdata),
    .pendIn(pendIn), .enIn(enIn), .lvlIn(lvlIn),
    .rspValid(rspValid), .rspError(rspError), .rspRdata(rspRdata),
    .domainEnable(domainEnable), .srcMode(srcMode), .srcTarget(srcTarget),
    .setPendStb(setPendStb), .clrPendStb(clrPendStb),
    .setEnStb(setEnStb), .clrEnStb(clrEnStb),
    .genMsgStb(genMsgStb), .genMsgHart(genMsgHart), .genMsgEiid(genMsgEiid),
    .rescanStb(rescanStb)
  );
endmodule

// File: rtl/ird_chk.sv
module ird_chk #(
  parameter int ADDR_W  = 14,
  parameter int NUM_SRC = 40
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic                  reqWrite,
  input logic [ADDR_W-1:0]     reqAddr,
  input logic [2:0]            reqSize,
  input logic [31:0]           reqWdata,
  input logic                  rspValid,
  input logic                  rspError,
  input logic [31:0]           rspRdata,
  input logic                  domainEnable,
  input logic [3*NUM_SRC-1:0]  srcMode,
  input logic [32*NUM_SRC-1:0] srcTarget,
  input logic [NUM_SRC:1]      setPendStb,
  input logic [NUM_SRC:1]      clrPendStb,
  input logic [NUM_SRC:1]      setEnStb,
  input logic [NUM_SRC:1]      clrEnStb,
  input logic                  genMsgStb,
  input logic [13:0]           genMsgHart,
  input logic [10:0]           genMsgEiid,
  input logic                  rescanStb
);
  logic anyStb;
  assign anyStb = (|setPendStb) || (|clrPendStb) || (|setEnStb) || (|clrEnStb)
                || genMsgStb || rescanStb;

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  p_strobe_in_rsp_r2: assert property (@(posedge clk) disable iff (!rstN)
    anyStb |-> (rspValid && !rspError));

  p_bad_access_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqSize != 3'd4 || reqAddr[1:0] != 2'b00)) |=> (rspError && rspRdata == 32'd0));

  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqWrite) |=> ($stable(srcMode) && $stable(srcTarget) && $stable(domainEnable)));

  p_rescan_write_r12: assert property (@(posedge clk) disable iff (!rstN)
    rescanStb |-> $past(reqValid && reqWrite));

  p_genmsg_fields_r10: assert property (@(posedge clk) disable iff (!rstN)
    genMsgStb |-> (genMsgEiid == $past(reqWdata[10:0]) && genMsgHart == $past(reqWdata[31:18])));

  p_dcfg_fixed_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqSize == 3'd4 && reqAddr == '0)
      |=> (rspRdata[31] && rspRdata[2] && rspRdata[8] == domainEnable));
endmodule

bind ird_top ird_chk #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
  .rspValid(rspValid), .rspError(rspError), .rspRdata(rspRdata),
  .domainEnable(domainEnable), .srcMode(srcMode), .srcTarget(srcTarget),
  .setPendStb(setPendStb), .clrPendStb(clrPendStb), .setEnStb(setEnStb),
  .clrEnStb(clrEnStb), .genMsgStb(genMsgStb), .genMsgHart(genMsgHart),
  .genMsgEiid(genMsgEiid), .rescanStb(rescanStb)
);

// File: tb/sim_ird_top.sv
module sim_ird_top;
  localparam int NS = 40;
  localparam int NW = (NS + 32) / 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [13:0] reqAddr = '0;
  logic [2:0]  reqSize = 3'd4;
  logic [31:0] reqWdata = '0;
  logic [NS:1] pendIn = '0, enIn = '0, lvlIn = '0;
  logic        rspValid, rspError, domainEnable, genMsgStb, rescanStb;
  logic [31:0] rspRdata;
  logic [3*NS-1:0]  srcMode;
  logic [32*NS-1:0] srcTarget;
  logic [NS:1] setPendStb, clrPendStb, setEnStb, clrEnStb;
  logic [13:0] genMsgHart;
  logic [10:0] genMsgEiid;

  always #2 clk = ~clk;

  ird_top #(.ADDR_W(14), .NUM_SRC(NS)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .pendIn(pendIn), .enIn(enIn), .lvlIn(lvlIn),
    .rspValid(rspValid), .rspError(rspError), .rspRdata(rspRdata),
    .domainEnable(domainEnable), .srcMode(srcMode), .srcTarget(srcTarget),
    .setPendStb(setPendStb), .clrPendStb(clrPendStb), .setEnStb(setEnStb),
    .clrEnStb(clrEnStb), .genMsgStb(genMsgStb), .genMsgHart(genMsgHart),
    .genMsgEiid(genMsgEiid), .rescanStb(rescanStb)
  );

  typedef struct {
    logic        v, err, gm, rs;
    logic [31:0] rd;
    logic [NS:1] sp, cp, se, ce;
    logic [13:0] gh;
    logic [10:0] ge;
  } expT;

  expT   pend, expd;
  string pendTag = "R2", expTag = "R2";
  logic [2:0]  mMode [1:NS], nMode [1:NS];
  logic [31:0] mTgt  [1:NS], nTgt  [1:NS];
  logic        mIe = 1'b0, nIe = 1'b0;
  logic [31:0] mGen = '0, nGen = '0;
  int tests = 0, fails = 0;
  bit chkOn = 1'b0;

  function automatic expT idleExp();
    expT e;
    e.v = 0; e.err = 0; e.gm = 0; e.rs = 0; e.rd = '0;
    e.sp = '0; e.cp = '0; e.se = '0; e.ce = '0; e.gh = '0; e.ge = '0;
    return e;
  endfunction

  task automatic chkV(string tag, string what, logic [1279:0] act, logic [1279:0] exv);
    tests++;
    if (act !== exv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exv);
    end
  endtask

  function automatic logic [1279:0] flatMode();
    logic [1279:0] f = '0;
    for (int s = 1; s <= NS; s++) f[3*(s-1) +: 3] = mMode[s];
    return f;
  endfunction

  function automatic logic [1279:0] flatTgt();
    logic [1279:0] f = '0;
    for (int s = 1; s <= NS; s++) f[32*(s-1) +: 32] = mTgt[s];
    return f;
  endfunction

  // commit expectations and model state at each edge
  initial begin
    pend = idleExp();
    expd = idleExp();
    for (int s = 1; s <= NS; s++) begin
      mMode[s] = '0; nMode[s] = '0; mTgt[s] = '0; nTgt[s] = '0;
    end
    forever begin
      @(posedge clk);
      #1;
      expd = pend; expTag = pendTag;
      pend = idleExp(); pendTag = "R2";
      mMode = nMode; mTgt = nTgt; mIe = nIe; mGen = nGen;
    end
  end

  // compare on every clock
  always @(negedge clk) begin
    if (chkOn) begin
      chkV(expTag, "rspValid", 1280'(rspValid), 1280'(expd.v));
      chkV(expTag, "rspError", 1280'(rspError), 1280'(expd.err));
      chkV(expTag, "rspRdata", 1280'(rspRdata), 1280'(expd.rd));
      chkV(expTag, "setPendStb", 1280'(setPendStb), 1280'(expd.sp));
      chkV(expTag, "clrPendStb", 1280'(clrPendStb), 1280'(expd.cp));
      chkV(expTag, "setEnStb", 1280'(setEnStb), 1280'(expd.se));
      chkV(expTag, "clrEnStb", 1280'(clrEnStb), 1280'(expd.ce));
      chkV("R10", "genMsgStb", 1280'(genMsgStb), 1280'(expd.gm));
      if (expd.gm) begin
        chkV("R10", "genMsgHart", 1280'(genMsgHart), 1280'(expd.gh));
        chkV("R10", "genMsgEiid", 1280'(genMsgEiid), 1280'(expd.ge));
      end
      chkV("R12", "rescanStb", 1280'(rescanStb), 1280'(expd.rs));
      chkV("R3", "domainEnable", 1280'(domainEnable), 1280'(mIe));
      chkV("R4", "srcMode", 1280'(srcMode), flatMode());
      chkV("R5", "srcTarget", 1280'(srcTarget), flatTgt());
    end
  end

  function automatic logic [31:0] wordOf(logic [NS:1] v, int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) begin
      int s = 32 * w + b;
      if (s >= 1 && s <= NS) r[b] = v[s];
    end
    return r;
  endfunction

  function automatic logic [NS:1] wordStb(logic [31:0] wd, int w);
    logic [NS:1] r = '0;
    for (int s = 1; s <= NS; s++) if (s / 32 == w && wd[s % 32]) r[s] = 1'b1;
    return r;
  endfunction

  function automatic logic [NS:1] numStb(logic [31:0] n);
    logic [NS:1] r = '0;
    if (n >= 1 && n <= NS) r[n] = 1'b1;
    return r;
  endfunction

  task automatic req(bit w, int unsigned addr, int sz, logic [31:0] wd, string tag);
    bit hit = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = 14'(addr); reqSize = 3'(sz); reqWdata = wd;
    pend = idleExp(); pend.v = 1; pendTag = tag;
    if (addr % 4 == 0 && sz == 4) begin
      if (addr == 0) begin
        hit = 1;
        if (w) nIe = wd[8]; else pend.rd = 32'h8000_0004 | (32'(mIe) << 8);
      end else if (addr >= 4 && addr < 4 + 4 * NS) begin
        int s = (addr - 4) / 4 + 1;
        hit = 1;
        if (w) nMode[s] = wd[10] ? 3'd0 : wd[2:0]; else pend.rd = 32'(mMode[s]);
      end else if (addr >= 32'h3004 && addr < 32'h3004 + 4 * NS) begin
        int s = (addr - 32'h3004) / 4 + 1;
        hit = 1;
        if (w) nTgt[s] = wd & 32'hFFFF_F7FF; else pend.rd = mTgt[s];
      end else if (addr == 32'h3000) begin
        hit = 1;
        if (w) begin
          nGen = wd & 32'hFFFC_0FFF; pend.gm = 1; pend.gh = wd[31:18]; pend.ge = wd[10:0];
        end else pend.rd = mGen;
      end else if (addr >= 32'h1C00 && addr < 32'h1C00 + 4 * NW) begin
        hit = 1;
        if (w) pend.sp = wordStb(wd, (addr - 32'h1C00) / 4); else pend.rd = wordOf(pendIn, (addr - 32'h1C00) / 4);
      end else if (addr >= 32'h1D00 && addr < 32'h1D00 + 4 * NW) begin
        hit = 1;
        if (w) pend.cp = wordStb(wd, (addr - 32'h1D00) / 4); else pend.rd = wordOf(lvlIn, (addr - 32'h1D00) / 4);
      end else if (addr >= 32'h1E00 && addr < 32'h1E00 + 4 * NW) begin
        hit = 1;
        if (w) pend.se = wordStb(wd, (addr - 32'h1E00) / 4); else pend.rd = wordOf(enIn, (addr - 32'h1E00) / 4);
      end else if (addr >= 32'h1F00 && addr < 32'h1F00 + 4 * NW) begin
        hit = 1;
        if (w) pend.ce = wordStb(wd, (addr - 32'h1F00) / 4);
      end else if (addr == 32'h1CDC || addr == 32'h2000) begin
        hit = 1; if (w) pend.sp = numStb(wd);
      end else if (addr == 32'h2004) begin
        hit = 1; if (w) pend.sp = numStb({wd[7:0], wd[15:8], wd[23:16], wd[31:24]});
      end else if (addr == 32'h1DDC) begin
        hit = 1; if (w) pend.cp = numStb(wd);
      end else if (addr == 32'h1EDC) begin
        hit = 1; if (w) pend.se = numStb(wd);
      end else if (addr == 32'h1FDC) begin
        hit = 1; if (w) pend.ce = numStb(wd);
      end
    end
    pend.err = !hit;
    pend.rs  = w && hit;
    @(posedge clk);
    #1;
    reqValid = 1'b0;
  endtask

  initial begin : watchdog
    #(4 * 100000);
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // reset state (R3 R4 R5 R2)
    chkV("R3", "reset domainEnable", 1280'(domainEnable), '0);
    chkV("R4", "reset srcMode", 1280'(srcMode), '0);
    chkV("R5", "reset srcTarget", 1280'(srcTarget), '0);
    chkV("R2", "reset rspValid", 1280'(rspValid), '0);
    chkOn = 1'b1;

    // R3 domain register
    req(0, 32'h0000, 4, 0, "R3");
    req(1, 32'h0000, 4, 32'hFFFF_FFFF, "R3");
    req(0, 32'h0000, 4, 0, "R3");
    req(1, 32'h0000, 4, 32'h0000_00FF, "R3");
    req(0, 32'h0000, 4, 0, "R3");
    req(1, 32'h0000, 4, 32'h0000_0100, "R3");

    // R4 mode array, back-to-back write then read
    req(1, 32'h0004, 4, 32'h6, "R4");
    req(0, 32'h0004, 4, 0, "R4");
    req(1, 32'h00A0, 4, 32'h3FF, "R4");
    req(0, 32'h00A0, 4, 0, "R4");
    req(1, 32'h00A0, 4, 32'h405, "R4");
    req(0, 32'h00A0, 4, 0, "R4");
    req(1, 32'h0010, 4, 32'h5, "R4");
    req(0, 32'h00A4, 4, 0, "R11");

    // R5 targets
    req(1, 32'h3004, 4, 32'hFFFF_FFFF, "R5");
    req(0, 32'h3004, 4, 0, "R5");
    req(1, 32'h30A0, 4, 32'h1234_5ABC, "R5");
    req(0, 32'h30A0, 4, 0, "R5");
    req(1, 32'h30A4, 4, 32'h1, "R11");

    // R6 word reads
    @(negedge clk);
    pendIn = 40'hA5_DEAD_BEEF; enIn = 40'hFF_0F0F_0F0F; lvlIn = 40'h3C_1234_5679;
    req(0, 32'h1C00, 4, 0, "R6");
    req(0, 32'h1C04, 4, 0, "R6");
    req(0, 32'h1D00, 4, 0, "R6");
    req(0, 32'h1D04, 4, 0, "R6");
    req(0, 32'h1E00, 4, 0, "R6");
    req(0, 32'h1E04, 4, 0, "R6");
    req(0, 32'h1F00, 4, 0, "R6");
    req(0, 32'h1F04, 4, 0, "R6");
    req(0, 32'h1C08, 4, 0, "R11");

    // R7 word writes
    req(1, 32'h1C00, 4, 32'hFFFF_FFFF, "R7");
    req(0, 32'h1C00, 4, 0, "R6");
    req(1, 32'h1C04, 4, 32'hFFFF_FFFF, "R7");
    req(1, 32'h1D00, 4, 32'h8000_0011, "R7");
    req(1, 32'h1E04, 4, 32'h0000_0081, "R7");
    req(1, 32'h1F00, 4, 32'h0000_0000, "R7");
    req(1, 32'h1F04, 4, 32'h0000_0100, "R7");

    // R8 by-number
    req(1, 32'h1CDC, 4, 32'd5, "R8");
    req(1, 32'h1DDC, 4, 32'd40, "R8");
    req(1, 32'h1EDC, 4, 32'd0, "R8");
    req(1, 32'h1FDC, 4, 32'd41, "R8");
    req(1, 32'h1FDC, 4, 32'd1, "R8");
    req(1, 32'h2000, 4, 32'd17, "R8");
    req(0, 32'h1CDC, 4, 0, "R8");
    req(0, 32'h2000, 4, 0, "R8");

    // R9 big-endian by-number
    req(1, 32'h2004, 4, 32'h0700_0000, "R9");
    req(1, 32'h2004, 4, 32'h0000_0007, "R9");
    req(1, 32'h2004, 4, 32'h2800_0000, "R9");

    // R10 generate message
    req(1, 32'h3000, 4, 32'hFFFF_FFFF, "R10");
    req(0, 32'h3000, 4, 0, "R10");
    req(1, 32'h3000, 4, 32'h0004_5123, "R10");
    req(0, 32'h3000, 4, 0, "R10");

    // R1 bad size / alignment
    req(0, 32'h0006, 4, 0, "R1");
    req(0, 32'h0000, 2, 0, "R1");
    req(1, 32'h0005, 4, 32'h7, "R1");
    req(1, 32'h3000, 1, 32'h1, "R1");
    req(1, 32'h1C00, 8, 32'hF, "R1");

    // R11 undefined offsets
    req(0, 32'h3FFC, 4, 0, "R11");
    req(1, 32'h2008, 4, 32'h1, "R11");
    req(1, 32'h1CE0, 4, 32'h1, "R11");

    // R12 / R2 idle gap
    repeat (3) @(negedge clk);
    req(1, 32'h0000, 4, 32'h0, "R12");

    repeat (3) @(negedge clk);
    chkOn = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule